// File: doc/BRIEF.md
# Modem status flags and interrupt request

This block keeps the status byte of a packet data modem that a host microcontroller drives through task writes and a set of mode bits. It tracks four flags: interrupt pending, data buffer free, transmit symbol buffer nearly empty, and receive de-interleave overflow. The host polls the byte or waits on an active-low, open-drain interrupt line. Reading the byte acknowledges the interrupt and clears the overflow flag.

The modem's datapath feeds the block with single-cycle events: transmit-ready, receive-complete, late receive task and symbol strobe. It also supplies the current fill level of the transmit interleave buffer. When a flag rises because of ordinary modem activity, the interrupt is raised. When a flag is forced high by a reset task or by a change of the transmit/receive or power-save mode bits, the flag is set quietly and no interrupt follows. The block detects mode-bit changes itself by comparing the mode inputs against their values on the previous clock. The first clock after a hardware reset counts as a quiet reset.

The block also flags when the transmit path should send the mid-level symbol, halfway between the +1 and -1 levels, because the interleave buffer has run dry.

Top module: `modem_status_irq`

## Requirements
- R1: The status byte carries interrupt pending in bit 7, buffer free in bit 6, transmit buffer empty in bit 5 and receive overflow in bit 4. Bits 3..0 read 0. The byte shows the registered flags, so a read returns the value from before that cycle's update.
- R2: A task write whose code is neither NULL (0) nor RESET (1) clears buffer free on the next clock. This takes priority over a ready or complete event in the same cycle. A NULL task write changes nothing.
- R3: A transmit-ready event in transmit mode, or a receive-complete event in receive mode, sets buffer free. If the flag was 0, interrupt pending is set. The event of the other mode has no effect.
- R4: A RESET task (code 1), a change of the transmit/receive bit, a change of the power-save bit, and the first clock after hardware reset are quiet events. After one, buffer free is 1, transmit buffer empty equals the transmit mode bit, and overflow is 0. None of these rises sets interrupt pending.
- R5: In transmit mode, when the fill level is below 2 and no qualifying task is waiting for its symbol strobe, transmit buffer empty sets. A 0-to-1 change of the flag sets interrupt pending.
- R6: After a non-NULL, non-RESET task write in transmit mode, transmit buffer empty clears on the first symbol strobe in a later cycle. Until then it is not set again.
- R7: In receive mode, transmit buffer empty reads 0 from the clock after the mode bit is 0. In transmit mode, overflow reads 0.
- R8: A late-receive-task event in receive mode sets overflow, even when a status read happens in the same cycle. If overflow was 0, interrupt pending is set.
- R9: Overflow clears on a status read with no late event in that cycle, and on any quiet event.
- R10: A status read clears interrupt pending on the next clock unless a flag rise that raises the interrupt happens in the same cycle. Quiet events leave interrupt pending unchanged.
- R11: The interrupt pin is driven low (drive output 1) exactly while interrupt pending is 1 and the interrupt-enable mode bit is 1.
- R12: The mid-level output is 1 exactly when the transmit bit is 1 and the fill level is 0.
- R13: While hardware reset is held, the status byte reads 0x40 and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_wr | input | 1 | Task write strobe |
| task_code | input | TASK_W | Task code (0 NULL, 1 RESET) |
| mode_tx | input | 1 | 1 transmit, 0 receive |
| mode_psave | input | 1 | Power-save mode bit |
| mode_irq_en | input | 1 | Interrupt pin enable |
| tx_ready_evt | input | 1 | Transmit path ready for data and next task |
| rx_done_evt | input | 1 | Receive task finished, data in buffer |
| tx_fill | input | FILL_W | Symbols left in transmit interleave buffer |
| sym_strobe | input | 1 | One pulse per symbol time |
| rx_late_evt | input | 1 | Receive task arrived too late |
| stat_rd | input | 1 | Host status read strobe |
| stat_byte | output | 8 | Status byte |
| irq_n_oe | output | 1 | 1 = pull open-drain interrupt pin low |
| tx_mid_level | output | 1 | Send mid-level symbol |

## Verification
Assertions check on every cycle that a working task clears buffer free, that quiet events set buffer free and clear overflow, that the empty flag stays low in receive mode and drops on the awaited symbol strobe, that a late event sets overflow, and that a read with no same-cycle rise clears the interrupt. Only the bench's scenarios can show that quiet rises really leave the interrupt untouched. The same holds for the set-over-read priority when overflow is already set, for the wrong-mode event being ignored, and for the pin following the enable bit. The bench compares a behavioural model against these cases clock by clock.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic       irq;
    logic       bfree;
    logic       txempty;
    logic       rxovf;
    logic [3:0] rsvd;
  } stat_byte_t;
endpackage

// File: rtl/mstat_mode_watch.sv
module mstat_mode_watch #(
  parameter int N_MODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MODE-1:0] mode_in,
  output logic              quiet_evt
);
  logic [N_MODE-1:0] prev_q;
  logic [N_MODE-1:0] diff;
  logic              primed_q;

  genvar gi;
  generate
    for (gi = 0; gi < N_MODE; gi++) begin : g_bit
      assign diff[gi] = primed_q & (mode_in[gi] ^ prev_q[gi]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[gi] <= 1'b0;
        else        prev_q[gi] <= mode_in[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assign quiet_evt = ~primed_q | (|diff);
endmodule

// File: rtl/mstat_bfree_ctl.sv
module mstat_bfree_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  input  logic work_task,
  input  logic ready_evt,
  output logic bfree_q,
  output logic rise_loud
);
  logic bfree_d;
  logic bfree_en;

  always_comb begin
    bfree_en = quiet | work_task | ready_evt;
    bfree_d  = bfree_q;
    if (quiet)          bfree_d = 1'b1;
    else if (work_task) bfree_d = 1'b0;
    else if (ready_evt) bfree_d = 1'b1;
    rise_loud = bfree_en & bfree_d & ~bfree_q & ~quiet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bfree_q <= 1'b1;
    else if (bfree_en) bfree_q <= bfree_d;
  end

  AST_BFREE_WORK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (work_task && !quiet) |=> !bfree_q); // R2
  AST_BFREE_QUIET_SET: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> bfree_q); // R4
endmodule

// File: rtl/mstat_txempty_ctl.sv
module mstat_txempty_ctl #(
  parameter int FILL_W   = 6,
  parameter int LOW_MARK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tx,
  input  logic              quiet,
  input  logic              work_task,
  input  logic              sym_strobe,
  input  logic [FILL_W-1:0] tx_fill,
  output logic              empty_q,
  output logic              rise_loud,
  output logic              mid_level
);
  localparam logic [FILL_W-1:0] LOW_V = FILL_W'(LOW_MARK);

  logic pend_q, pend_d;
  logic empty_d;
  logic low_fill;

  always_comb begin
    low_fill = (tx_fill < LOW_V);
    empty_d  = empty_q;
    pend_d   = pend_q;
    if (!mode_tx) begin
      empty_d = 1'b0;
      pend_d  = 1'b0;
    end else if (quiet) begin
      empty_d = 1'b1;
      pend_d  = 1'b0;
    end else begin
      if (pend_q && sym_strobe)                 empty_d = 1'b0;
      else if (low_fill && !pend_q && !work_task) empty_d = 1'b1;
      if (work_task)       pend_d = 1'b1;
      else if (sym_strobe) pend_d = 1'b0;
    end
    rise_loud = empty_d & ~empty_q & ~quiet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_d;
      pend_q  <= pend_d;
    end
  end

  assign mid_level = mode_tx & (tx_fill == '0);

  AST_EMPTY_RX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_tx |=> !empty_q); // R7
  AST_EMPTY_STROBE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tx && !quiet && pend_q && sym_strobe) |=> !empty_q); // R6
endmodule

// File: rtl/mstat_rxovf_ctl.sv
module mstat_rxovf_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_tx,
  input  logic quiet,
  input  logic late_evt,
  input  logic stat_rd,
  output logic ovf_q,
  output logic rise_loud
);
  logic ovf_d;
  logic ovf_en;

  always_comb begin
    ovf_en = mode_tx | quiet | late_evt | stat_rd;
    ovf_d  = ovf_q;
    if (mode_tx || quiet) ovf_d = 1'b0;
    else if (late_evt)    ovf_d = 1'b1;
    else if (stat_rd)     ovf_d = 1'b0;
    rise_loud = ovf_en & ovf_d & ~ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  AST_OVF_LATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (late_evt && !mode_tx && !quiet) |=> ovf_q); // R8
  AST_OVF_QUIET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !ovf_q); // R9
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int TASK_W     = 4,
  parameter int TASK_NULL  = 0,
  parameter int TASK_RESET = 1,
  parameter int FILL_W     = 6,
  parameter int LOW_MARK   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_wr,
  input  logic [TASK_W-1:0] task_code,
  input  logic              mode_tx,
  input  logic              mode_psave,
  input  logic              mode_irq_en,
  input  logic              tx_ready_evt,
  input  logic              rx_done_evt,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              sym_strobe,
  input  logic              rx_late_evt,
  input  logic              stat_rd,
  output logic [7:0]        stat_byte,
  output logic              irq_n_oe,
  output logic              tx_mid_level
);
  import mstat_pkg::*;

  localparam logic [TASK_W-1:0] CODE_NULL  = TASK_W'(TASK_NULL);
  localparam logic [TASK_W-1:0] CODE_RESET = TASK_W'(TASK_RESET);

  logic       mode_quiet, quiet, reset_task, work_task, ready_sel;
  logic       bfree_q, empty_q, ovf_q;
  logic       bf_rise, em_rise, ov_rise, any_rise;
  logic       irq_q, irq_d, irq_en;
  stat_byte_t sb;

  always_comb begin
    reset_task = task_wr & (task_code == CODE_RESET);
    work_task  = task_wr & (task_code != CODE_NULL) & (task_code != CODE_RESET);
    quiet      = mode_quiet | reset_task;
    ready_sel  = mode_tx ? tx_ready_evt : rx_done_evt;
  end

  mstat_mode_watch #(.N_MODE(2)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   ({mode_psave, mode_tx}),
    .quiet_evt (mode_quiet)
  );

  mstat_bfree_ctl u_bfree (
    .clk       (clk),
    .rst_n     (rst_n),
    .quiet     (quiet),
    .work_task (work_task),
    .ready_evt (ready_sel),
    .bfree_q   (bfree_q),
    .rise_loud (bf_rise)
  );

  mstat_txempty_ctl #(.FILL_W(FILL_W), .LOW_MARK(LOW_MARK)) u_empty (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_tx    (mode_tx),
    .quiet      (quiet),
    .work_task  (work_task),
    .sym_strobe (sym_strobe),
    .tx_fill    (tx_fill),
    .empty_q    (empty_q),
    .rise_loud  (em_rise),
    .mid_level  (tx_mid_level)
  );

  mstat_rxovf_ctl u_ovf (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_tx   (mode_tx),
    .quiet     (quiet),
    .late_evt  (rx_late_evt),
    .stat_rd   (stat_rd),
    .ovf_q     (ovf_q),
    .rise_loud (ov_rise)
  );

  always_comb begin
    any_rise = bf_rise | em_rise | ov_rise;
    irq_en   = any_rise | stat_rd;
    irq_d    = any_rise ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  always_comb begin
    sb.irq     = irq_q;
    sb.bfree   = bfree_q;
    sb.txempty = empty_q;
    sb.rxovf   = ovf_q;
    sb.rsvd    = '0;
  end

  assign stat_byte = sb;
  assign irq_n_oe  = irq_q & mode_irq_en;

  AST_IRQ_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !bf_rise && !em_rise && !ov_rise) |=> !irq_q); // R10
  AST_IRQ_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !stat_rd && !ov_rise) |=> (irq_q == $past(irq_q))); // R4
  AST_PIN_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_oe |-> stat_byte[7]); // R11
endmodule

// File: tb/modem_status_irq_tb.sv
module modem_status_irq_tb_top;
  localparam int TASK_W = 4;
  localparam int FILL_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              task_wr, mode_tx, mode_psave, mode_irq_en;
  logic [TASK_W-1:0] task_code;
  logic              tx_ready_evt, rx_done_evt, sym_strobe, rx_late_evt, stat_rd;
  logic [FILL_W-1:0] tx_fill;
  logic [7:0]        stat_byte;
  logic              irq_n_oe, tx_mid_level;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R13";

  // behavioural model state
  bit m_irq, m_bf, m_em, m_ov, m_pend, m_primed;
  bit m_ptx, m_pps;

  always #4 clk = ~clk;

  modem_status_irq dut_i (
    .clk(clk), .rst_n(rst_n), .task_wr(task_wr), .task_code(task_code),
    .mode_tx(mode_tx), .mode_psave(mode_psave), .mode_irq_en(mode_irq_en),
    .tx_ready_evt(tx_ready_evt), .rx_done_evt(rx_done_evt), .tx_fill(tx_fill),
    .sym_strobe(sym_strobe), .rx_late_evt(rx_late_evt), .stat_rd(stat_rd),
    .stat_byte(stat_byte), .irq_n_oe(irq_n_oe), .tx_mid_level(tx_mid_level)
  );

  task automatic check(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit q, wt, rise, nbf, nem, nov, npd, nirq;
    if (!rst_n) begin
      m_irq = 0; m_bf = 1; m_em = 0; m_ov = 0; m_pend = 0; m_primed = 0;
    end else begin
      q  = !m_primed || (mode_tx != m_ptx) || (mode_psave != m_pps)
           || (task_wr && task_code == 1);
      wt = task_wr && task_code > 1;
      nbf = q ? 1 : wt ? 0 : (mode_tx ? tx_ready_evt : rx_done_evt) ? 1 : m_bf;
      nem = m_em; npd = m_pend;
      if (!mode_tx) begin nem = 0; npd = 0; end
      else if (q) begin nem = 1; npd = 0; end
      else begin
        if (m_pend && sym_strobe) nem = 0;
        else if (tx_fill < 2 && !m_pend && !wt) nem = 1;
        npd = wt ? 1 : sym_strobe ? 0 : m_pend;
      end
      nov = (mode_tx || q) ? 0 : rx_late_evt ? 1 : stat_rd ? 0 : m_ov;
      rise = (nbf && !m_bf && !q) || (nem && !m_em && !q) || (nov && !m_ov);
      nirq = rise ? 1 : stat_rd ? 0 : m_irq;
      m_bf = nbf; m_em = nem; m_ov = nov; m_pend = npd; m_irq = nirq;
      m_primed = 1; m_ptx = mode_tx; m_pps = mode_psave;
    end
    #2;
    if (!done) begin
      check(stat_byte, {m_irq, m_bf, m_em, m_ov, 4'b0}, {cur_req, " byte (R1)"});
      check(irq_n_oe, m_irq && mode_irq_en, {cur_req, " pin (R11)"});
      check(tx_mid_level, mode_tx && tx_fill == 0, {cur_req, " mid (R12)"});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_task(input int code);
    task_wr = 1; task_code = TASK_W'(code);
    @(negedge clk); task_wr = 0; task_code = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; task_wr = 0; task_code = '0; mode_tx = 1; mode_psave = 0;
    mode_irq_en = 1; tx_ready_evt = 0; rx_done_evt = 0; tx_fill = 6'd10;
    sym_strobe = 0; rx_late_evt = 0; stat_rd = 0;
    idle(3);
    check(stat_byte, 8'h40, "R13 reset byte");
    check(irq_n_oe, 0, "R13 reset pin");
    rst_n = 1;
    idle(2);
    cur_req = "R4";  check(stat_byte, 8'h60, "R4 quiet after reset");
    cur_req = "R2";  wr_task(3); check(stat_byte[6], 0, "R2 work task clears bfree");
    check(stat_byte[5], 1, "R6 empty held until strobe");
    cur_req = "R6";  sym_strobe = 1; idle(1); sym_strobe = 0;
    check(stat_byte, 8'h00, "R6 strobe clears empty");
    cur_req = "R3";  tx_ready_evt = 1; idle(1); tx_ready_evt = 0;
    check(stat_byte, 8'hC0, "R3 tx ready sets bfree+irq");
    check(irq_n_oe, 1, "R11 pin low");
    cur_req = "R10"; stat_rd = 1; idle(1); stat_rd = 0;
    check(stat_byte, 8'h40, "R10 read clears irq");
    cur_req = "R5";  tx_fill = 6'd1; idle(1);
    check(stat_byte, 8'hE0, "R5 low fill sets empty+irq");
    stat_rd = 1; idle(1); stat_rd = 0;
    cur_req = "R12"; tx_fill = 6'd0; idle(1);
    check(tx_mid_level, 1, "R12 mid level");
    check(stat_byte, 8'h60, "R1 layout");
    cur_req = "R6";  wr_task(4); tx_fill = 6'd20; idle(2);
    sym_strobe = 1; idle(1); sym_strobe = 0; idle(2);
    cur_req = "R4";  wr_task(5); wr_task(1);
    check(stat_byte, 8'h60, "R4 reset task quiet");
    cur_req = "R2";  wr_task(0); check(stat_byte[6], 1, "R2 NULL no effect");
    cur_req = "R11"; mode_irq_en = 0; wr_task(2); tx_ready_evt = 1; idle(1);
    tx_ready_evt = 0;
    check(irq_n_oe, 0, "R11 pin disabled");
    check(stat_byte[7], 1, "R11 irq pending");
    stat_rd = 1; idle(1); stat_rd = 0; mode_irq_en = 1;
    cur_req = "R7";  mode_tx = 0; idle(2);
    check(stat_byte, 8'h40, "R7 rx empty low, R4 quiet");
    cur_req = "R8";  rx_late_evt = 1; idle(1); rx_late_evt = 0;
    check(stat_byte, 8'hD0, "R8 late sets ovf+irq");
    rx_late_evt = 1; stat_rd = 1; idle(1); rx_late_evt = 0; stat_rd = 0;
    check(stat_byte, 8'h50, "R8 set beats read");
    cur_req = "R9";  stat_rd = 1; idle(1); stat_rd = 0;
    check(stat_byte, 8'h40, "R9 read clears ovf");
    cur_req = "R8";  rx_late_evt = 1; stat_rd = 1; idle(1);
    rx_late_evt = 0; stat_rd = 0;
    check(stat_byte, 8'hD0, "R8 rise with read");
    cur_req = "R9";  mode_psave = 1; idle(1);
    check(stat_byte, 8'hC0, "R9 psave clears ovf, R10 irq kept");
    stat_rd = 1; idle(1); stat_rd = 0;
    rx_late_evt = 1; idle(1); rx_late_evt = 0; wr_task(1);
    check(stat_byte[4], 0, "R9 reset task clears ovf");
    stat_rd = 1; idle(1); stat_rd = 0;
    cur_req = "R3";  wr_task(6); rx_done_evt = 1; idle(1); rx_done_evt = 0;
    check(stat_byte, 8'hC0, "R3 rx done");
    stat_rd = 1; idle(1); stat_rd = 0;
    wr_task(6); tx_ready_evt = 1; idle(1); tx_ready_evt = 0;
    check(stat_byte, 8'h00, "R3 wrong-mode ready ignored");
    cur_req = "R12"; tx_fill = 6'd0; idle(1);
    check(tx_mid_level, 0, "R12 no mid in rx");
    check(stat_byte[5], 0, "R7 empty low rx");
    cur_req = "R4";  mode_tx = 1; idle(2);
    idle(3);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule